// File: doc/BRIEF.md
# Serial Control Port with Shadow/Active Register File

This block is the slave end of a serial configuration link. It runs in the chip's sync clock domain and oversamples the serial clock, chip select and data pins. A master drives chip select low and shifts an 8-bit command byte. The command byte holds a read/write flag and a register address. A data phase follows, and its length is set by the addressed register. Write data is staged in a shadow copy of the register file. Reads always return the active copy. The whole shadow copy moves into the active copy only when the update input is held high long enough to count as a real strobe.

Register 0 bit 0 selects the bit order, and register 0 bit 1 selects the wiring. Both bits take effect only after an update. In three-wire mode, read data leaves on a dedicated output and the shared data line is only an input. In two-wire mode the shared line carries read data as well, and the dedicated output is never enabled. A separate abort input returns the protocol logic to the command phase without touching any register.

The serial side consists of plain level pins with no handshake. The master owns the pace of the link, so there is no back-pressure. The tristate pads sit outside the block, which provides an output value and an enable for each data pin.

Top module: `scp_ctrl_port`

## Requirements
- R1: The first 8 serial bits of a cycle form the command. Command bit 7 = 1 means read and 0 means write. Bits 4:0 are the register address. Bits 6:5 are ignored.
- R2: Data length depends on the address: address 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 1 byte. Any other address takes 1 byte. A write to it is dropped, and a read of it returns 0.
- R3: When active register 0 bit 0 is 0 (the reset value), the command and the data are shifted MSB first. When it is 1, both are shifted LSB first. A register's highest-numbered bit is its MSB.
- R4: Input bits are sampled on the rising serial-clock edge. Read data changes only after a falling edge, so the bit for each rising edge is launched on the falling edge that comes before it.
- R5: A completed write changes only the shadow copy. The active registers, which reads return, stay the same until an update commits.
- R6: Update commits the whole shadow copy once, on the second consecutive sync-clock cycle that it is sampled high. A pulse of one cycle is ignored. A long pulse commits only once.
- R7: In three-wire mode (active register 0 bit 1 = 0), read data is driven on the dedicated output with its enable high, and the shared-line enable stays low.
- R8: In two-wire mode (active register 0 bit 1 = 1), read data is driven on the shared line, and the dedicated-output enable never rises.
- R9: While abort is high, the cycle in progress is dropped. A partial write is discarded, both output enables fall, and the next bits form a new command even if chip select stays low.
- R10: Chip select high returns the logic to the command phase and drops the enables. Several complete cycles may follow one another within a single chip-select low period.
- R11: After reset, all shadow and active registers are zero and both enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sync clock; all pins are oversampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Shared data line, input side |
| sdio_o | output | 1 | Shared data line, output value |
| sdio_oe | output | 1 | Shared data line drive enable |
| sdo_o | output | 1 | Dedicated read-data output value |
| sdo_oe | output | 1 | Dedicated read-data output enable |
| io_abort | input | 1 | Abort the cycle in progress (level) |
| io_update | input | 1 | Commit shadow registers to active |
| active_o | output | NREGS*32 | Active register contents, register n at bits n*32 and up |

## Verification
The assertions assume that every input changes between sync-clock edges. They also assume the serial clock is slow enough that each of its levels spans several sync-clock samples, and that update is never raised in the cycle that completes a write or changes register 0. The bench drives every pin on the falling sync-clock edge, holds each serial-clock level for four cycles, and raises update only after a cycle has ended. Its update pulses are one, two and five cycles long, which covers the rejected width, the shortest accepted width and a width long enough to test for a repeat commit.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 5;
  localparam int IDX_W  = $clog2(REG_W);

  typedef enum logic { PH_CMD, PH_DATA } phase_t;

  // byte length of a register: mapped addresses cycle 1,2,4 bytes
  function automatic int reg_bytes(input logic [ADDR_W-1:0] a, input int nregs);
    int ai;
    ai = int'(a);
    if (ai < nregs) return 1 << (ai % 3);
    return 1;
  endfunction
endpackage

// File: rtl/scp_update_qual.sv
module scp_update_qual #(
  parameter int MIN_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_i,
  output logic commit_o
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] SAT  = CW'(MIN_CYC);
  localparam logic [CW-1:0] FIRE = CW'(MIN_CYC - 1);

  logic [CW-1:0] hi_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hi_cnt_q <= '0;
    else if (!upd_i)           hi_cnt_q <= '0;
    else if (hi_cnt_q != SAT)  hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  // fires once, on the MIN_CYC-th consecutive high sample
  assign commit_o = upd_i && (hi_cnt_q == FIRE);
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
  import scp_pkg::*;
#(
  parameter int NREGS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [REG_W-1:0]        wr_data,
  input  logic                    commit,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [REG_W-1:0]        rd_data,
  output logic [NREGS*REG_W-1:0]  active_flat
);
  logic [REG_W-1:0] act_arr [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    localparam int NB = reg_bytes(ADDR_W'(g), NREGS);
    localparam logic [REG_W-1:0] MASK =
      (NB >= 4) ? {REG_W{1'b1}} : REG_W'((64'd1 << (8 * NB)) - 64'd1);

    logic [REG_W-1:0] shadow_q;
    logic [REG_W-1:0] active_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= '0;
        active_q <= '0;
      end else begin
        if (wr_en && (wr_addr == ADDR_W'(g))) shadow_q <= wr_data & MASK;
        if (commit)                            active_q <= shadow_q;
      end
    end

    assign act_arr[g] = active_q;
    assign active_flat[g*REG_W +: REG_W] = active_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREGS; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = act_arr[i];
  end
endmodule

// File: rtl/scp_serial_fsm.sv
module scp_serial_fsm
  import scp_pkg::*;
#(
  parameter int NREGS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               sdi,
  input  logic               abort,
  input  logic               lsb_first,
  input  logic [REG_W-1:0]   rd_data,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [REG_W-1:0]   wr_data,
  output logic               dout,
  output logic               dout_en
);
  phase_t            phase_q;
  logic              sclk_q;
  logic [IDX_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  last_q;   // index of final data bit
  logic [7:0]        cmd_q;
  logic [REG_W-1:0]  acc_q;
  logic              rnw_q;
  logic [ADDR_W-1:0] addr_q;
  logic              dout_q;
  logic              oe_q;

  logic              rise, fall, idle;
  logic [2:0]        cmd_pos;
  logic [IDX_W-1:0]  data_pos;
  logic [7:0]        cmd_nxt;
  logic [REG_W-1:0]  acc_nxt;
  logic [IDX_W-1:0]  new_last;

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;
  assign idle = cs_n | abort;

  always_comb begin
    cmd_pos  = lsb_first ? cnt_q[2:0] : (3'd7 - cnt_q[2:0]);
    data_pos = lsb_first ? cnt_q : (last_q - cnt_q);
    cmd_nxt  = cmd_q;
    cmd_nxt[cmd_pos] = sdi;
    acc_nxt  = acc_q;
    acc_nxt[data_pos] = sdi;
    new_last = IDX_W'(reg_bytes(cmd_nxt[ADDR_W-1:0], NREGS) * 8 - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      last_q  <= '0;
      cmd_q   <= '0;
      acc_q   <= '0;
      rnw_q   <= 1'b0;
      addr_q  <= '0;
      dout_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (idle) begin
        phase_q <= PH_CMD;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
        dout_q  <= 1'b0;
      end else if (rise) begin
        if (phase_q == PH_CMD) begin
          cmd_q <= cmd_nxt;
          if (cnt_q == IDX_W'(7)) begin
            phase_q <= PH_DATA;
            cnt_q   <= '0;
            last_q  <= new_last;
            rnw_q   <= cmd_nxt[7];
            addr_q  <= cmd_nxt[ADDR_W-1:0];
            acc_q   <= '0;
            oe_q    <= cmd_nxt[7];
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          acc_q <= acc_nxt;
          if (cnt_q == last_q) begin
            phase_q <= PH_CMD;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end else if (fall && phase_q == PH_DATA && rnw_q) begin
        dout_q <= rd_data[data_pos];
      end
    end
  end

  assign wr_en   = !idle && rise && (phase_q == PH_DATA) && !rnw_q && (cnt_q == last_q);
  assign wr_data = acc_nxt;
  assign addr_o  = addr_q;
  assign dout    = dout_q;
  assign dout_en = oe_q;
endmodule

// File: rtl/scp_ctrl_port.sv
module scp_ctrl_port
  import scp_pkg::*;
#(
  parameter int NREGS       = 4,
  parameter int UPD_MIN_CYC = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sclk,
  input  logic                   cs_n,
  input  logic                   sdio_i,
  output logic                   sdio_o,
  output logic                   sdio_oe,
  output logic                   sdo_o,
  output logic                   sdo_oe,
  input  logic                   io_abort,
  input  logic                   io_update,
  output logic [NREGS*REG_W-1:0] active_o
);
  logic              wr_en, commit, dout, dout_en;
  logic [ADDR_W-1:0] addr;
  logic [REG_W-1:0]  wr_data, rd_data;
  logic              lsb_first, two_wire;

  assign lsb_first = active_o[0];
  assign two_wire  = active_o[1];

  scp_serial_fsm #(.NREGS(NREGS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdio_i),
    .abort(io_abort), .lsb_first(lsb_first), .rd_data(rd_data),
    .wr_en(wr_en), .addr_o(addr), .wr_data(wr_data),
    .dout(dout), .dout_en(dout_en)
  );

  scp_update_qual #(.MIN_CYC(UPD_MIN_CYC)) u_upd (
    .clk(clk), .rst_n(rst_n), .upd_i(io_update), .commit_o(commit)
  );

  scp_regfile #(.NREGS(NREGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(addr), .wr_data(wr_data),
    .commit(commit), .rd_addr(addr), .rd_data(rd_data), .active_flat(active_o)
  );

  assign sdio_o  = two_wire & dout;
  assign sdio_oe = two_wire & dout_en;
  assign sdo_o   = ~two_wire & dout;
  assign sdo_oe  = ~two_wire & dout_en;
endmodule

// File: rtl/scp_ctrl_port_chk.sv
module scp_ctrl_port_chk #(
  parameter int NREGS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sclk,
  input logic                 cs_n,
  input logic                 io_abort,
  input logic                 io_update,
  input logic                 sdo_o,
  input logic                 sdo_oe,
  input logic                 sdio_oe,
  input logic [NREGS*32-1:0]  active_o
);
  // R5: nothing moves into the active copy while update is low
  a_r5_hold_without_update: assert property (@(posedge clk) disable iff (!rst_n)
    !io_update |=> $stable(active_o));

  // R6: the first high sample of update never commits
  a_r6_first_sample_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_update) |=> $stable(active_o));

  // R9: abort drops both drivers
  a_r9_abort_drops_enables: assert property (@(posedge clk) disable iff (!rst_n)
    io_abort |=> (!sdo_oe && !sdio_oe));

  // R10: chip select high drops both drivers
  a_r10_cs_drops_enables: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!sdo_oe && !sdio_oe));

  // R4: dedicated output holds unless a falling serial edge was just seen
  a_r4_launch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !($past(sclk, 2) && !$past(sclk))) |-> $stable(sdo_o));
endmodule

bind scp_ctrl_port scp_ctrl_port_chk #(.NREGS(NREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .io_abort(io_abort),
  .io_update(io_update), .sdo_o(sdo_o), .sdo_oe(sdo_oe), .sdio_oe(sdio_oe),
  .active_o(active_o)
);

// File: tb/scp_ctrl_port_tb.sv
module scp_ctrl_port_tb_top;
  localparam int NREGS = 4;
  localparam int HALF  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdio_i = 1'b0, io_abort = 1'b0, io_update = 1'b0;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe;
  logic [NREGS*32-1:0] active_o;

  int n_checks = 0, n_fail = 0, uhi = 0;
  logic [31:0] m_act [NREGS];
  logic [31:0] m_shd [NREGS];

  always #5 clk = ~clk;

  scp_ctrl_port #(.NREGS(NREGS)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .io_abort(io_abort), .io_update(io_update), .active_o(active_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model: update counts as a commit on its second high sample (R6)
  always @(posedge clk) begin
    if (!rst_n) begin
      uhi = 0;
      for (int i = 0; i < NREGS; i++) begin m_act[i] = '0; m_shd[i] = '0; end
    end else if (io_update) begin
      uhi++;
      if (uhi == 2) for (int i = 0; i < NREGS; i++) m_act[i] = m_shd[i];
    end else uhi = 0;
  end

  // compare on every clock: active copy (R5/R6) and driver rules (R7/R8)
  always @(negedge clk) if (rst_n) begin
    for (int i = 0; i < NREGS; i++) chk("R5 active copy", active_o[i*32 +: 32], m_act[i]);
    if (m_act[0][1] && sdo_oe) chk("R8 sdo_oe in two-wire", 32'(sdo_oe), 32'd0);
    if (!m_act[0][1] && sdio_oe) chk("R7 sdio_oe in three-wire", 32'(sdio_oe), 32'd0);
  end

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int nbytes(input logic [4:0] a);
    if (int'(a) < NREGS) return 1 << (int'(a) % 3);
    return 1;
  endfunction

  // one cycle; stop_at >= 0 cuts it after that rising edge by abort or cs
  task automatic xfer(input logic [7:0] cmd, input logic [31:0] wdata,
                      output logic [31:0] rdata, input int stop_at, input bit by_cs);
    bit lsb, tw, rnw, b;
    int nbits, pos;
    logic [4:0] a;
    lsb = m_act[0][0]; tw = m_act[0][1];
    rnw = cmd[7]; a = cmd[4:0];
    nbits = 8 * nbytes(a);
    rdata = '0;
    for (int k = 0; k < 8 + nbits; k++) begin
      if (k < 8) begin pos = lsb ? k : 7 - k; b = cmd[pos]; end
      else begin pos = lsb ? k - 8 : nbits - 1 - (k - 8); b = wdata[pos]; end
      sclk = 1'b0; sdio_i = b;
      clk_n(HALF);
      if (rnw && k >= 8) begin
        if (tw) rdata[pos] = sdio_oe ? sdio_o : 1'bx;
        else    rdata[pos] = sdo_oe ? sdo_o : 1'bx;
      end
      sclk = 1'b1;
      clk_n(HALF);
      if (k == stop_at) begin
        if (by_cs) cs_n = 1'b1; else io_abort = 1'b1;
        clk_n(3);
        chk(by_cs ? "R10 enables after cs high" : "R9 enables under abort",
            {30'd0, sdo_oe, sdio_oe}, 32'd0);
        io_abort = 1'b0; sclk = 1'b0;
        clk_n(2);
        return;
      end
    end
    sclk = 1'b0;
    clk_n(HALF);
    if (!rnw && int'(a) < NREGS)
      m_shd[a] = (nbits == 32) ? wdata : (wdata & ((32'd1 << nbits) - 32'd1));
  endtask

  task automatic wr(input logic [7:0] cmd, input logic [31:0] d);
    logic [31:0] r;
    cs_n = 1'b0; clk_n(2);
    xfer(cmd, d, r, -1, 1'b0);
    cs_n = 1'b1; clk_n(3);
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a);
    logic [31:0] r, e;
    cs_n = 1'b0; clk_n(2);
    xfer({3'b100, a}, 32'd0, r, -1, 1'b0);
    cs_n = 1'b1; clk_n(3);
    e = (int'(a) < NREGS) ? m_act[a] : 32'd0;
    chk(req, r, e);
  endtask

  task automatic upd(input int n);
    io_update = 1'b1; clk_n(n);
    io_update = 1'b0; clk_n(3);
  endtask

  initial begin
    logic [31:0] r;
    clk_n(5);
    // R11: reset state
    chk("R11 active after reset", active_o[31:0] | active_o[63:32] | active_o[95:64] | active_o[127:96], 32'd0);
    chk("R11 enables after reset", {30'd0, sdo_oe, sdio_oe}, 32'd0);
    rst_n = 1'b1; clk_n(3);

    // R5: write stays in shadow until update
    wr(8'h01, 32'h0000A55A);
    rd_chk("R5 read before update", 5'd1);
    chk("R5 value still old", active_o[63:32], 32'd0);
    upd(2);
    rd_chk("R1 R3 R7 msb read of reg1", 5'd1);
    chk("R1 reg1 after update", active_o[63:32], 32'h0000A55A);

    // R6: one-cycle pulse ignored, long pulse commits once
    wr(8'h02, 32'h12345678);
    upd(1);
    chk("R6 short pulse ignored", active_o[95:64], 32'd0);
    upd(5);
    rd_chk("R2 four-byte read of reg2", 5'd2);
    chk("R6 long pulse commits", active_o[95:64], 32'h12345678);

    // R1: command bits 6:5 ignored
    wr(8'h61, 32'h0000BEEF);
    upd(2);
    chk("R1 junk bits ignored", active_o[63:32], 32'h0000BEEF);

    // R2: unmapped address, 1 byte, dropped; reads 0
    wr(8'h09, 32'h000000FF);
    upd(2);
    rd_chk("R2 unmapped reads zero", 5'd9);
    rd_chk("R2 reg3 untouched", 5'd3);

    // R10: back-to-back cycles in one chip-select window
    cs_n = 1'b0; clk_n(2);
    xfer(8'h03, 32'h77, r, -1, 1'b0);
    xfer(8'h81, 32'h0, r, -1, 1'b0);
    cs_n = 1'b1; clk_n(3);
    chk("R10 second cycle read", r, 32'h0000BEEF);
    upd(2);
    chk("R10 first cycle write", active_o[127:96], 32'h77);

    // R9: abort mid-write, then a fresh command under the same cs
    cs_n = 1'b0; clk_n(2);
    xfer(8'h01, 32'h1111, r, 12, 1'b0);
    xfer(8'h03, 32'h42, r, -1, 1'b0);
    xfer(8'h82, 32'h0, r, 10, 1'b0);
    cs_n = 1'b1; clk_n(3);
    upd(2);
    chk("R9 partial write discarded", active_o[63:32], 32'h0000BEEF);
    chk("R9 cycle after abort", active_o[127:96], 32'h42);

    // R10: cs high mid-write drops it
    cs_n = 1'b0; clk_n(2);
    xfer(8'h01, 32'h2222, r, 15, 1'b1);
    clk_n(3);
    upd(2);
    chk("R10 cut write dropped", active_o[63:32], 32'h0000BEEF);

    // R3: switch to LSB-first
    wr(8'h00, 32'h01);
    upd(2);
    wr(8'h02, 32'hCAFE0123);
    upd(2);
    chk("R3 lsb-first write", active_o[95:64], 32'hCAFE0123);
    rd_chk("R3 lsb-first read", 5'd2);

    // R8: two-wire, LSB-first then MSB-first
    wr(8'h00, 32'h03);
    upd(2);
    rd_chk("R8 two-wire lsb read", 5'd2);
    wr(8'h00, 32'h02);
    upd(2);
    rd_chk("R8 two-wire msb read", 5'd1);
    rd_chk("R4 R8 two-wire reg0 read", 5'd0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule